// File: doc/BRIEF.md
# Frame Airtime Duration Calculator

This block works out how long an OFDM frame occupies the medium, in microseconds, from the frame length in bytes, a bit rate in steps of 100 kbit/s and a channel-width mode. It adds the interframe space and the preamble time to the time taken by a whole number of data symbols. The number of symbols comes from a rounded-up division that a restoring sequential divider carries out, one quotient bit per clock.

A caller drives the operands, pulses `start_i` for one cycle and waits for `done_o`. A request for an acknowledgement time sets `ack_i`, and the block then uses the fixed length of an acknowledgement frame instead of `len_i`. Two narrow-channel modes scale the bit rate down before the division. A rate that reduces to zero gives an error and a saturated result instead of a division.

The control path has three states. IDLE waits for a start and captures the operands (transition IDLE->PREP on `start_i`). PREP forms the dividend and divisor; it returns to IDLE with an error result when the divisor is zero (PREP->IDLE) and otherwise loads the divider (PREP->WAIT). WAIT holds until the divider reports its quotient, then publishes the duration (WAIT->IDLE). The divider has its own two states, D_IDLE and D_RUN. It moves D_IDLE->D_RUN on a load and D_RUN->D_IDLE after exactly `DIV_W` steps.

Top module: `airtime_calc`

## Requirements
- R1: After reset `done_o` and `err_o` are low and `dur_o` is zero.
- R2: The frame bit count is `PLCP_BITS` (default 22) plus eight times the byte length.
- R3: With `ack_i` high at the start, the length used is `ACK_BYTES` (default 10) and `len_i` has no effect on the result.
- R4: The symbol count is ceil(bits*10 / (effective_rate * symbol_time)).
- R5: The result is SIFS + preamble + symbol_time * symbols, using the constants of `mode_i`: 0 = default (SIFS 16, preamble 20, symbol 4), 1 = turbo (8, 14, 4), 2 = half (32, 40, 8), 3 = quarter (64, 80, 16).
- R6: The effective rate is `rate_i` in modes 0 and 1, ceil(`rate_i`/2) in mode 2 and ceil(`rate_i`/4) in mode 3.
- R7: For a non-zero divisor, `done_o` is first high after the (`DIV_W`+3)-th rising edge, counting the edge that accepted `start_i` as the first (35 with `DIV_W` = 32).
- R8: `done_o` is high for exactly one cycle, and `dur_o` and `err_o` hold their values until the next `done_o`.
- R9: A `start_i` that arrives while a computation is in progress is ignored and does not change the pending result.
- R10: A zero divisor (effective rate 0) makes `err_o` high and `dur_o` all ones together with `done_o`, which is first high after the 2nd edge counting the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| ack_i | input | 1 | Use the acknowledgement frame length |
| mode_i | input | 2 | Channel-width mode (0 default, 1 turbo, 2 half, 3 quarter) |
| len_i | input | LEN_W | Frame length in bytes |
| rate_i | input | RATE_W | Bit rate in units of 100 kbit/s |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Zero divisor flag, valid with `done_o` |
| dur_o | output | DIV_W | Airtime in microseconds |

## Verification
Two situations are hard to reach from the ports. One is a second start landing while the divider is mid-way. The bench issues a request and then, a few cycles into the divide, pulses start again with very different operands. It checks that the first result arrives on schedule and that no second strobe follows. The other is the narrow-mode rounding at tiny rates, where rates 1 to 3 in quarter mode must all round up to one and not collapse to zero. The sweep covers rates 0 to 7 in every mode and crosses them with lengths from zero to the maximum, so both the error path and the smallest non-zero divisors come up.

// File: rtl/airtime_pkg.sv
package airtime_pkg;

    typedef enum logic [1:0] {
        BW_DEFAULT = 2'd0,
        BW_TURBO   = 2'd1,
        BW_HALF    = 2'd2,
        BW_QUARTER = 2'd3
    } bw_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_WAIT = 2'd2
    } calc_state_e;

    typedef enum logic {
        D_IDLE = 1'b0,
        D_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/airtime_mode_sel.sv
module airtime_mode_sel
    import airtime_pkg::*;
#(
    parameter int RATE_W   = 10,
    parameter int CONST_W  = 8,
    parameter int DEF_SIFS = 16,
    parameter int DEF_PRE  = 20,
    parameter int DEF_SYM  = 4,
    parameter int TRB_SIFS = 8,
    parameter int TRB_PRE  = 14,
    parameter int TRB_SYM  = 4,
    parameter int HLF_SIFS = 32,
    parameter int HLF_PRE  = 40,
    parameter int HLF_SYM  = 8,
    parameter int QTR_SIFS = 64,
    parameter int QTR_PRE  = 80,
    parameter int QTR_SYM  = 16
) (
    input  bw_mode_e            mode_i,
    input  logic [RATE_W-1:0]   rate_i,
    output logic [CONST_W-1:0]  sifs_o,
    output logic [CONST_W-1:0]  pre_o,
    output logic [CONST_W-1:0]  sym_o,
    output logic [RATE_W-1:0]   eff_rate_o
);

    logic [RATE_W-1:0] rate_half;
    logic [RATE_W-1:0] rate_quarter;

    // Round-up halving and quartering without discarding any bit.
    assign rate_half    = {1'b0, rate_i[RATE_W-1:1]} + RATE_W'(rate_i[0]);
    assign rate_quarter = {2'b00, rate_i[RATE_W-1:2]} + RATE_W'(|rate_i[1:0]);

    always_comb begin
        unique case (mode_i)
            BW_TURBO: begin
                sifs_o     = CONST_W'(TRB_SIFS);
                pre_o      = CONST_W'(TRB_PRE);
                sym_o      = CONST_W'(TRB_SYM);
                eff_rate_o = rate_i;
            end
            BW_HALF: begin
                sifs_o     = CONST_W'(HLF_SIFS);
                pre_o      = CONST_W'(HLF_PRE);
                sym_o      = CONST_W'(HLF_SYM);
                eff_rate_o = rate_half;
            end
            BW_QUARTER: begin
                sifs_o     = CONST_W'(QTR_SIFS);
                pre_o      = CONST_W'(QTR_PRE);
                sym_o      = CONST_W'(QTR_SYM);
                eff_rate_o = rate_quarter;
            end
            default: begin
                sifs_o     = CONST_W'(DEF_SIFS);
                pre_o      = CONST_W'(DEF_PRE);
                sym_o      = CONST_W'(DEF_SYM);
                eff_rate_o = rate_i;
            end
        endcase
    end

endmodule

// File: rtl/airtime_ceil_div.sv
module airtime_ceil_div
    import airtime_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic         valid_o
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    div_state_e       dstate_q, dstate_n;
    logic [W-1:0]     rem_q, quo_q, dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       shifted;
    logic             fits;
    logic [W-1:0]     diff;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    assign shifted = {rem_q, quo_q[W-1]};
    assign fits    = shifted >= {1'b0, dsr_q};
    assign diff    = shifted[W-1:0] - dsr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dstate_q <= D_IDLE;
        else        dstate_q <= dstate_n;
    end

    always_comb begin
        dstate_n = dstate_q;
        unique case (dstate_q)
            D_IDLE: if (load_i) dstate_n = D_RUN;
            D_RUN:  if (cnt_q == LAST_STEP) dstate_n = D_IDLE;
            default: dstate_n = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (dstate_q)
                D_IDLE: begin
                    if (load_i) begin
                        rem_q <= '0;
                        quo_q <= dividend_i;
                        dsr_q <= divisor_i;
                        cnt_q <= '0;
                    end
                end
                D_RUN: begin
                    rem_q <= fits ? diff : shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], fits};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) valid_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign quot_o = quo_q;

endmodule

// File: rtl/airtime_calc.sv
module airtime_calc
    import airtime_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int RATE_W    = 10,
    parameter int CONST_W   = 8,
    parameter int DIV_W     = 32,
    parameter int PLCP_BITS = 22,
    parameter int ACK_BYTES = 10,
    parameter int DEF_SIFS  = 16,
    parameter int DEF_PRE   = 20,
    parameter int DEF_SYM   = 4,
    parameter int TRB_SIFS  = 8,
    parameter int TRB_PRE   = 14,
    parameter int TRB_SYM   = 4,
    parameter int HLF_SIFS  = 32,
    parameter int HLF_PRE   = 40,
    parameter int HLF_SYM   = 8,
    parameter int QTR_SIFS  = 64,
    parameter int QTR_PRE   = 80,
    parameter int QTR_SYM   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic [1:0]        mode_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              done_o,
    output logic              err_o,
    output logic [DIV_W-1:0]  dur_o
);

    calc_state_e        state_q, state_n;
    bw_mode_e           mode_q;
    logic [LEN_W-1:0]   len_q;
    logic [RATE_W-1:0]  rate_q;

    logic [CONST_W-1:0] sifs, pre, sym;
    logic [RATE_W-1:0]  eff_rate;

    logic [DIV_W-1:0]   bits, scaled, divisor, dividend;
    logic               zero_div;
    logic               div_load, div_valid;
    logic [DIV_W-1:0]   quot, air, dur_calc;

    airtime_mode_sel #(
        .RATE_W(RATE_W), .CONST_W(CONST_W),
        .DEF_SIFS(DEF_SIFS), .DEF_PRE(DEF_PRE), .DEF_SYM(DEF_SYM),
        .TRB_SIFS(TRB_SIFS), .TRB_PRE(TRB_PRE), .TRB_SYM(TRB_SYM),
        .HLF_SIFS(HLF_SIFS), .HLF_PRE(HLF_PRE), .HLF_SYM(HLF_SYM),
        .QTR_SIFS(QTR_SIFS), .QTR_PRE(QTR_PRE), .QTR_SYM(QTR_SYM)
    ) u_mode (
        .mode_i     (mode_q),
        .rate_i     (rate_q),
        .sifs_o     (sifs),
        .pre_o      (pre),
        .sym_o      (sym),
        .eff_rate_o (eff_rate)
    );

    // Operand formation: bits*10 plus (divisor-1) gives a rounded-up quotient.
    assign bits     = DIV_W'(PLCP_BITS) + (DIV_W'(len_q) << 3);
    assign scaled   = (bits << 3) + (bits << 1);
    assign divisor  = DIV_W'(eff_rate) * DIV_W'(sym);
    assign zero_div = (divisor == '0);
    assign dividend = scaled + divisor - DIV_W'(1);
    assign div_load = (state_q == ST_PREP) && !zero_div;

    airtime_ceil_div #(.W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .quot_o     (quot),
        .valid_o    (div_valid)
    );

    assign air      = DIV_W'(sym) * quot;
    assign dur_calc = DIV_W'(sifs) + DIV_W'(pre) + air;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_n = ST_PREP;
            ST_PREP: state_n = zero_div ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (div_valid) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Operand capture and result outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= BW_DEFAULT;
            len_q  <= '0;
            rate_q <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            dur_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q <= bw_mode_e'(mode_i);
                        len_q  <= ack_i ? LEN_W'(ACK_BYTES) : len_i;
                        rate_q <= rate_i;
                    end
                end
                ST_PREP: begin
                    if (zero_div) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                        dur_o  <= '1;
                    end
                end
                ST_WAIT: begin
                    if (div_valid) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b0;
                        dur_o  <= dur_calc;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/airtime_calc_chk.sv
module airtime_calc_chk
    import airtime_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             done_o,
    input  logic             err_o,
    input  logic [DIV_W-1:0] dur_o,
    input  logic [1:0]       state_i
);

    localparam int LAT_OK  = DIV_W + 3;
    localparam int LAT_ERR = 2;

    logic [15:0] since_start;

    // Edges since the accepting edge, counting that edge as the first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   since_start <= '0;
        else if (state_i == ST_IDLE && start_i)       since_start <= 16'd1;
        else if (done_o)                              since_start <= '0;
        else if (since_start != '0)                   since_start <= since_start + 16'd1;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dur_o) |-> done_o);

    assert_err_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && done_o |-> dur_o == '1);

    assert_err_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> since_start == 16'(LAT_ERR));

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !err_o |-> since_start == 16'(LAT_OK));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_WAIT |=> state_i != ST_PREP);

    assert_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> since_start != '0);

endmodule

bind airtime_calc airtime_calc_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .err_o   (err_o),
    .dur_o   (dur_o),
    .state_i (state_q)
);

// File: tb/tb_airtime_calc.sv
`timescale 1ns/1ps
module tb_airtime_calc;

    localparam int LEN_W  = 12;
    localparam int RATE_W = 10;
    localparam int DIV_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              ack_i = 1'b0;
    logic [1:0]        mode_i = 2'd0;
    logic [LEN_W-1:0]  len_i = '0;
    logic [RATE_W-1:0] rate_i = '0;
    logic              done_o, err_o;
    logic [DIV_W-1:0]  dur_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    airtime_calc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
        .mode_i(mode_i), .len_i(len_i), .rate_i(rate_i),
        .done_o(done_o), .err_o(err_o), .dur_o(dur_o)
    );

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected airtime from the requirement arithmetic (R2, R4, R5, R6, R10).
    function automatic longint model(int m, int r, int l, bit ack, output bit err);
        int sifs, pre, sym, eff, len_used;
        longint bits, dsor, n;
        case (m)
            1: begin sifs = 8;  pre = 14; sym = 4;  eff = r; end
            2: begin sifs = 32; pre = 40; sym = 8;  eff = (r + 1) / 2; end
            3: begin sifs = 64; pre = 80; sym = 16; eff = (r + 3) / 4; end
            default: begin sifs = 16; pre = 20; sym = 4; eff = r; end
        endcase
        len_used = ack ? 10 : l;
        dsor = longint'(eff) * sym;
        if (dsor == 0) begin
            err = 1'b1;
            return 64'hFFFF_FFFF;
        end
        err  = 1'b0;
        bits = 22 + 8 * longint'(len_used);
        n    = (bits * 10 + dsor - 1) / dsor;
        return (sifs + pre + sym * n) & 64'hFFFF_FFFF;
    endfunction

    // Issue one request and return the edge count at which done appears.
    task automatic issue(int m, int r, int l, bit ack, output int edges);
        @(negedge clk);
        mode_i = 2'(m); rate_i = RATE_W'(r); len_i = LEN_W'(l); ack_i = ack;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        edges = 1;
        while (!done_o && edges < 100) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic run_one(int m, int r, int l, bit ack, string req);
        int  edges;
        bit  e_err;
        longint e_dur;
        e_dur = model(m, r, l, ack, e_err);
        issue(m, r, l, ack, edges);
        check({req, " dur"}, dur_o, e_dur);
        check({req, " err R10"}, err_o, e_err);
        check(e_err ? "R10 latency" : "R7 latency", edges, e_err ? 2 : DIV_W + 3);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int rates[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 60, 120, 540, 1023};
        int lens[7]   = '{0, 1, 10, 14, 100, 1500, 4095};
        int edges;
        longint first_dur;
        bit e_err;

        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 done", done_o, 0);
        check("R1 err", err_o, 0);
        check("R1 dur", dur_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6 R10: sweep modes, rates, lengths
        for (int m = 0; m < 4; m++) begin
            for (int ri = 0; ri < 12; ri++) begin
                for (int li = 0; li < 7; li++) begin
                    run_one(m, rates[ri], lens[li], 1'b0,
                            (rates[ri] == 0) ? "R10" : (m >= 2) ? "R6 R5" : "R2 R4 R5");
                end
                // R3: acknowledgement length overrides len_i
                run_one(m, rates[ri], 2000, 1'b1, "R3");
            end
        end

        // R8: result and error flag hold, strobe is a single cycle
        run_one(0, 60, 100, 1'b0, "R8 setup");
        first_dur = model(0, 60, 100, 1'b0, e_err);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R8 done low", done_o, 0);
        end
        check("R8 dur held", dur_o, first_dur);
        check("R8 err held", err_o, 0);

        // R9: second start while busy is ignored
        first_dur = model(1, 90, 300, 1'b0, e_err);
        @(negedge clk);
        mode_i = 2'd1; rate_i = 10'd90; len_i = 12'd300; ack_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        edges = 1;
        repeat (4) begin @(negedge clk); edges++; end
        mode_i = 2'd3; rate_i = 10'd1; len_i = 12'd4095;
        start_i = 1'b1;
        @(negedge clk);
        edges++;
        start_i = 1'b0;
        while (!done_o && edges < 100) begin
            @(negedge clk);
            edges++;
        end
        check("R9 dur", dur_o, first_dur);
        check("R9 latency", edges, DIV_W + 3);
        edges = 0;
        for (int k = 0; k < 45; k++) begin
            @(negedge clk);
            if (done_o) edges++;
        end
        check("R9 no second done", edges, 0);
        check("R9 dur kept", dur_o, first_dur);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule